// File: doc/BRIEF.md
# Reset Release Sequencer

This block gathers the chip's internal reset requests and turns them into an orderly, two-stage release. Any request line drives the open-drain reset pad low through a pull-down output, marks its own sticky bit in a status register and restarts a tick counter. The counter advances only on cycles where the oscillator-derived enable is high. Once the pad has been held for a fixed number of ticks, the pull-down lets go. The processor reset is then kept for a shorter, fixed number of further ticks, so that the pad is always free before the vector fetch begins.

Request line 0 is the supply-monitor (low-voltage) request. A sequence started by power-on or by that request also raises a separate deep-reset output. This output is meant for registers that must survive ordinary resets. Software reads the status vector and clears it with a read strobe. The power-on bit is set only by the asynchronous power-on input.

Top module: `reset_sequencer`

## Requirements
- R1: While `porN` is low and just after it rises, `pinPullDown`, `cpuRst` and `fullRst` are 1 and `status` equals 1 (bit 0 is the power-on bit; every other bit is 0). The power-on sequence then runs as in R2 and R3.
- R2: `pinPullDown` stays 1 for exactly PIN_TICKS clock edges at which `tickEn` is 1 (default 4096). Edges where `tickEn` is 0 do not count.
- R3: After `pinPullDown` falls, `cpuRst` stays 1 for exactly CPU_TICKS further edges with `tickEn` high (default 64). `cpuRst` never falls while `pinPullDown` is 1 or in the cycle right after it falls.
- R4: Any bit of `rstReq` that is high at a clock edge makes `pinPullDown` and `cpuRst` 1 from the next cycle. This holds for every source, not only the low-voltage one.
- R5: A request that arrives during the pad-hold phase or the processor-hold phase restarts the pad-hold count from zero.
- R6: Request bit i sets `status` bit i+1, so the low-voltage request (`rstReq[0]`) sets bit 1. Coincident requests set several bits. Bits stay set until they are cleared.
- R7: A clock edge with `statusRd` high clears every `status` bit. A request sampled at the same edge still sets its bit.
- R8: `fullRst` is 1 for a sequence started by power-on or by `rstReq[0]`. It stays 1 through restarts by other sources until `cpuRst` falls. It is 0 for sequences started only by other sources.
- R9: Once a sequence completes with no new request, `pinPullDown`, `cpuRst` and `fullRst` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| tickEn | input | 1 | Oscillator-derived count enable |
| rstReq | input | NUM_SRC | Internal reset requests; bit 0 is low-voltage |
| statusRd | input | 1 | Status read strobe; clears the status at the edge |
| pinPullDown | output | 1 | 1 pulls the external reset pad low |
| cpuRst | output | 1 | Processor reset, active high |
| fullRst | output | 1 | Deep reset for power-on/low-voltage-only registers |
| status | output | NUM_SRC+1 | Sticky reset cause bits; bit 0 is power-on |

## Verification
Several stimulus patterns drive the main sequence:
- A power-on release and single low-voltage or other-source pulses, with `tickEn` held high, establish the basic hold lengths.
- Stretches where `tickEn` toggles in both phases separate tick counting from cycle counting.
- A second request 101 ticks into the pad hold checks that the count restarts rather than continues.
- A non-low-voltage request during the processor-hold phase of a low-voltage sequence shows that the pad is re-asserted and that the deep reset persists.

Coincident requests, and a read that lands in the same cycle as a request, tell apart a per-bit set from a whole-register overwrite.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_HOLD  = 2'd1,
    SEQ_DELAY = 2'd2
  } seqState_t;

  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic latchReq;
    logic readClr;
  } seqStrobe_t;

endpackage

// File: rtl/rstseq_datapath.sv
module rstseq_datapath
  import rstseq_pkg::*;
#(
  parameter int NUM_SRC   = 3,
  parameter int PIN_TICKS = 4096,
  parameter int CPU_TICKS = 64
) (
  input  logic               clk,
  input  logic               porN,
  input  seqStrobe_t         strobe,
  input  logic [NUM_SRC-1:0] rstReq,
  output logic               pinLast,
  output logic               cpuLast,
  output logic [NUM_SRC:0]   status
);

  localparam int MAX_TICKS = (PIN_TICKS > CPU_TICKS) ? PIN_TICKS : CPU_TICKS;
  localparam int CNT_W     = (MAX_TICKS > 1) ? $clog2(MAX_TICKS) : 1;

  logic [CNT_W-1:0] tickCnt;

  // shared tick counter, reused by both hold phases
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      tickCnt <= '0;
    end else if (strobe.cntClear) begin
      tickCnt <= '0;
    end else if (strobe.cntInc) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  assign pinLast = (tickCnt == CNT_W'(PIN_TICKS - 1));
  assign cpuLast = (tickCnt == CNT_W'(CPU_TICKS - 1));

  // power-on cause bit: set only by the asynchronous input
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      status[0] <= 1'b1;
    end else if (strobe.readClr) begin
      status[0] <= 1'b0;
    end
  end

  // one sticky cause bit per request source; a set beats a read clear
  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_cause
    always_ff @(posedge clk or negedge porN) begin
      if (!porN) begin
        status[gi+1] <= 1'b0;
      end else if (strobe.latchReq && rstReq[gi]) begin
        status[gi+1] <= 1'b1;
      end else if (strobe.readClr) begin
        status[gi+1] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int LVI_IDX = 0
) (
  input  logic               clk,
  input  logic               porN,
  input  logic               tickEn,
  input  logic               statusRd,
  input  logic [NUM_SRC-1:0] rstReq,
  input  logic               pinLast,
  input  logic               cpuLast,
  output seqStrobe_t         strobe,
  output logic               pinPullDown,
  output logic               cpuRst,
  output logic               fullRst
);

  seqState_t seqState, seqNext;
  logic      fullNext;
  logic      anyReq;

  assign anyReq = |rstReq;

  always_comb begin
    seqNext         = seqState;
    strobe          = '0;
    strobe.latchReq = anyReq;
    strobe.readClr  = statusRd;
    if (anyReq) begin
      seqNext         = SEQ_HOLD;
      strobe.cntClear = 1'b1;
    end else begin
      unique case (seqState)
        SEQ_HOLD: begin
          if (tickEn) begin
            if (pinLast) begin
              seqNext         = SEQ_DELAY;
              strobe.cntClear = 1'b1;
            end else begin
              strobe.cntInc = 1'b1;
            end
          end
        end
        SEQ_DELAY: begin
          if (tickEn) begin
            if (cpuLast) begin
              seqNext         = SEQ_IDLE;
              strobe.cntClear = 1'b1;
            end else begin
              strobe.cntInc = 1'b1;
            end
          end
        end
        default: begin
          seqNext = SEQ_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    if (anyReq && rstReq[LVI_IDX]) begin
      fullNext = 1'b1;
    end else if (seqNext == SEQ_IDLE) begin
      fullNext = 1'b0;
    end else begin
      fullNext = fullRst;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      seqState <= SEQ_HOLD;
      fullRst  <= 1'b1;
    end else begin
      seqState <= seqNext;
      fullRst  <= fullNext;
    end
  end

  assign pinPullDown = (seqState == SEQ_HOLD);
  assign cpuRst      = (seqState != SEQ_IDLE);

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rstseq_pkg::*;
#(
  parameter int NUM_SRC   = 3,
  parameter int LVI_IDX   = 0,
  parameter int PIN_TICKS = 4096,
  parameter int CPU_TICKS = 64
) (
  input  logic               clk,
  input  logic               porN,
  input  logic               tickEn,
  input  logic [NUM_SRC-1:0] rstReq,
  input  logic               statusRd,
  output logic               pinPullDown,
  output logic               cpuRst,
  output logic               fullRst,
  output logic [NUM_SRC:0]   status
);

  seqStrobe_t strobe;
  logic       pinLast;
  logic       cpuLast;

  rstseq_ctrl #(
    .NUM_SRC(NUM_SRC),
    .LVI_IDX(LVI_IDX)
  ) ctrl_i (
    .clk        (clk),
    .porN       (porN),
    .tickEn     (tickEn),
    .statusRd   (statusRd),
    .rstReq     (rstReq),
    .pinLast    (pinLast),
    .cpuLast    (cpuLast),
    .strobe     (strobe),
    .pinPullDown(pinPullDown),
    .cpuRst     (cpuRst),
    .fullRst    (fullRst)
  );

  rstseq_datapath #(
    .NUM_SRC  (NUM_SRC),
    .PIN_TICKS(PIN_TICKS),
    .CPU_TICKS(CPU_TICKS)
  ) dp_i (
    .clk    (clk),
    .porN   (porN),
    .strobe (strobe),
    .rstReq (rstReq),
    .pinLast(pinLast),
    .cpuLast(cpuLast),
    .status (status)
  );

endmodule

// File: rtl/reset_sequencer_checker.sv
module reset_sequencer_checker #(
  parameter int NUM_SRC = 3,
  parameter int LVI_IDX = 0
) (
  input logic               clk,
  input logic               porN,
  input logic [NUM_SRC-1:0] rstReq,
  input logic               statusRd,
  input logic               pinPullDown,
  input logic               cpuRst,
  input logic               fullRst,
  input logic [NUM_SRC:0]   status
);

  a_r3_pin_within_cpu: assert property (@(posedge clk) disable iff (!porN)
    pinPullDown |-> cpuRst);

  a_r3_release_order: assert property (@(posedge clk) disable iff (!porN)
    $fell(cpuRst) |-> (!pinPullDown && !$past(pinPullDown)));

  a_r4_req_pulls_pin: assert property (@(posedge clk) disable iff (!porN)
    (|rstReq) |=> (pinPullDown && cpuRst));

  a_r6_cause_bits_set: assert property (@(posedge clk) disable iff (!porN)
    (|rstReq) |=> ((status[NUM_SRC:1] & $past(rstReq)) == $past(rstReq)));

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!porN)
    (statusRd && !(|rstReq)) |=> (status == '0));

  a_r8_lvi_deep: assert property (@(posedge clk) disable iff (!porN)
    rstReq[LVI_IDX] |=> fullRst);

  a_r9_deep_within_cpu: assert property (@(posedge clk) disable iff (!porN)
    fullRst |-> cpuRst);

endmodule

bind reset_sequencer reset_sequencer_checker #(
  .NUM_SRC(NUM_SRC),
  .LVI_IDX(LVI_IDX)
) chk_i (
  .clk        (clk),
  .porN       (porN),
  .rstReq     (rstReq),
  .statusRd   (statusRd),
  .pinPullDown(pinPullDown),
  .cpuRst     (cpuRst),
  .fullRst    (fullRst),
  .status     (status)
);

// File: tb/reset_sequencer_tb_top.sv
module reset_sequencer_tb_top;

  localparam int NSRC = 3;
  localparam int PINT = 4096;
  localparam int CPUT = 64;

  logic            clk = 1'b0;
  logic            porN = 1'b0;
  logic            tickEn = 1'b0;
  logic            statusRd = 1'b0;
  logic [NSRC-1:0] rstReq = '0;
  logic            pinPullDown;
  logic            cpuRst;
  logic            fullRst;
  logic [NSRC:0]   status;

  always #4 clk = ~clk;

  reset_sequencer #(
    .NUM_SRC  (NSRC),
    .LVI_IDX  (0),
    .PIN_TICKS(PINT),
    .CPU_TICKS(CPUT)
  ) dut_i (
    .clk        (clk),
    .porN       (porN),
    .tickEn     (tickEn),
    .rstReq     (rstReq),
    .statusRd   (statusRd),
    .pinPullDown(pinPullDown),
    .cpuRst     (cpuRst),
    .fullRst    (fullRst),
    .status     (status)
  );

  int nRun  = 0;
  int nFail = 0;

  typedef struct {
    int    pinT;
    int    tailT;
    int    full;
    string tag;
  } seqItem_t;

  seqItem_t expQ[$];

  task automatic chk(string tag, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expectSeq(int p, int t, int f, string tag);
    seqItem_t it;
    it.pinT  = p;
    it.tailT = t;
    it.full  = f;
    it.tag   = tag;
    expQ.push_back(it);
  endtask

  task automatic pulseReq(logic [NSRC-1:0] v);
    rstReq = v;
    step();
    rstReq = '0;
  endtask

  task automatic waitIdle();
    while (cpuRst) step();
    step();
  endtask

  task automatic readStatus();
    statusRd = 1'b1;
    step();
    statusRd = 1'b0;
  endtask

  // monitor: measures each sequence at the ports and scores it
  int mPin  = 0;
  int mTail = 0;
  int mFull = 0;
  bit mBusy = 1'b0;

  always @(negedge clk) begin
    if (cpuRst) begin
      mBusy = 1'b1;
      if (fullRst) mFull = 1;
      if (pinPullDown) begin
        mTail = 0;
        if (tickEn) mPin++;
      end else if (tickEn) begin
        mTail++;
      end
    end else if (mBusy) begin
      if (expQ.size() == 0) begin
        chk("R4 unexpected sequence", 1, 0);
      end else begin
        seqItem_t it;
        it = expQ.pop_front();
        chk({"R2 pad hold ticks, ", it.tag}, mPin, it.pinT);
        chk({"R3 cpu tail ticks, ", it.tag}, mTail, it.tailT);
        chk({"R8 deep reset seen, ", it.tag}, mFull, it.full);
      end
      mBusy = 1'b0;
      mPin  = 0;
      mTail = 0;
      mFull = 0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL R9 watchdog: actual %0d expected %0d", 200000, 0);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) step();
    // R1: state held by power-on
    chk("R1 pad during power-on", int'(pinPullDown), 1);
    chk("R1 cpu during power-on", int'(cpuRst), 1);
    chk("R1 deep during power-on", int'(fullRst), 1);
    chk("R1 status after power-on", int'(status), 1);
    expectSeq(PINT, CPUT, 1, "R1 power-on");
    porN   = 1'b1;
    tickEn = 1'b1;
    waitIdle();
    chk("R9 pad idle", int'(pinPullDown), 0);
    chk("R9 cpu idle", int'(cpuRst), 0);
    chk("R9 deep idle", int'(fullRst), 0);
    chk("R6 power-on bit sticky", int'(status), 1);
    readStatus();
    chk("R7 read clears", int'(status), 0);

    // R4: low-voltage request
    expectSeq(PINT, CPUT, 1, "R4 low-voltage");
    pulseReq(3'b001);
    chk("R4 pad after lvi request", int'(pinPullDown), 1);
    chk("R8 deep after lvi request", int'(fullRst), 1);
    waitIdle();
    chk("R6 lvi bit", int'(status), 2);
    repeat (20) step();
    chk("R6 lvi bit sticky", int'(status), 2);

    // R7: read in the same cycle as a request
    expectSeq(PINT, CPUT, 0, "R7 source 2");
    statusRd = 1'b1;
    rstReq   = 3'b100;
    step();
    statusRd = 1'b0;
    rstReq   = '0;
    chk("R7 set wins over read", int'(status), 8);
    chk("R4 pad for other source", int'(pinPullDown), 1);
    chk("R8 no deep for other source", int'(fullRst), 0);
    waitIdle();
    readStatus();
    chk("R7 cleared again", int'(status), 0);

    // R6: coincident requests
    expectSeq(PINT, CPUT, 1, "R6 coincident");
    pulseReq(3'b101);
    chk("R6 coincident bits", int'(status), 10);
    waitIdle();
    readStatus();

    // R2/R3: gated ticks in both phases
    expectSeq(PINT, CPUT, 0, "R2 gated ticks");
    pulseReq(3'b010);
    for (int i = 0; i < 600; i++) begin
      tickEn = (i % 3 == 0);
      step();
    end
    tickEn = 1'b1;
    chk("R2 pad held while gated", int'(pinPullDown), 1);
    while (pinPullDown) step();
    for (int i = 0; i < 100; i++) begin
      tickEn = (i % 2 == 1);
      step();
    end
    tickEn = 1'b1;
    chk("R3 cpu held while gated", int'(cpuRst), 1);
    waitIdle();
    chk("R6 source 1 bit", int'(status), 4);
    readStatus();

    // R5: restart during pad hold
    expectSeq(PINT + 101, CPUT, 0, "R5 restart in hold");
    pulseReq(3'b010);
    repeat (100) step();
    pulseReq(3'b100);
    waitIdle();
    chk("R6 two sources over time", int'(status), 12);
    readStatus();

    // R5/R8: restart during processor hold of a low-voltage sequence
    expectSeq(2 * PINT, CPUT, 1, "R5 restart in delay");
    pulseReq(3'b001);
    while (pinPullDown) step();
    repeat (10) step();
    pulseReq(3'b010);
    chk("R5 pad re-asserted", int'(pinPullDown), 1);
    chk("R8 deep kept through restart", int'(fullRst), 1);
    waitIdle();
    chk("R9 deep released", int'(fullRst), 0);
    chk("R6 lvi and source 1", int'(status), 6);

    repeat (5) step();
    chk("R2 scoreboard drained", expQ.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule